// File: doc/BRIEF.md
# SDRAM Auto-Refresh Request Scheduler

This block decides when an SDRAM controller serving four partitions must issue an auto-refresh. Software programs a refresh interval and a per-partition enable mask through a single configuration write. A down-counter measures the interval in memory-clock cycles. When it runs out, the block raises a refresh request toward the command sequencer and holds it until the sequencer acknowledges.

Two events force an immediate refresh outside the periodic schedule. The first is any configuration write, including one that repeats the current value. The second is any access aimed at a partition whose enable bit is clear. Each forced refresh also restarts the counter at a full interval. After a memory-clock frequency change, software resynchronises refresh by rewriting the configuration. The clock-change indication itself triggers nothing. A zero interval silences the block completely. With every partition disabled, the counter freezes.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset the interval is zero and all partitions are disabled. refreshReq is low and stays low, even when an access is presented.
- R2: With a nonzero interval N and at least one enabled partition, the counter decrements once per clock. It raises a request every N cycles. Measured from the cycle after an acknowledge that follows a request's first cycle, the next request appears N-1 cycles later.
- R3: While the programmed interval is zero, no request is ever raised. This holds for configuration writes of a zero interval and for accesses to disabled partitions.
- R4: An access (accValid high, accPart = partition index 0..3) to a partition whose bit in the enable mask (bit i = partition i, 1 = enabled) is 0 raises refreshReq on the next clock. It also reloads the counter to the full interval.
- R5: An access to an enabled partition neither raises a request nor disturbs the counter.
- R6: Every configuration write with a nonzero interval raises refreshReq on the next clock and reloads the counter to the new interval. This holds even when the written value equals the old one.
- R7: With all enable bits clear, the counter holds and no periodic request occurs. An access still forces one request.
- R8: refreshReq is a register output. It stays high until refreshAck is sampled high, and falls on that clock unless a new trigger arrives in the same cycle.
- R9: Triggers that arrive while a request is pending merge into it, so one acknowledge clears it. A trigger in the acknowledge cycle keeps refreshReq high.
- R10: clkChange has no effect on requests or on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgInterval | input | CNT_W | Refresh interval in clocks; 0 disables refresh |
| cfgPartEn | input | NUM_PART | Partition enable mask, bit i = partition i |
| accValid | input | 1 | Access request valid |
| accPart | input | PART_W | Partition targeted by the access |
| clkChange | input | 1 | Memory-clock frequency change indication |
| refreshAck | input | 1 | Single-cycle acknowledge from the command sequencer |
| refreshReq | output | 1 | Pending auto-refresh request |

## Verification
Two cases are hard to reach from the ports. One is a trigger that lands exactly in the acknowledge cycle. The other is the merging of several triggers into one pending request. The stimulus holds off the acknowledge while periodic expiries and a rewrite accumulate. It then drives a configuration write in the same cycle as the acknowledge. Counter reloads are not visible directly, so they are observed through the distance to the next periodic request after each forced refresh.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic cfgLoad;   // capture new configuration and load the counter from it
    logic reload;    // restart counter from the stored interval
    logic dec;       // count one cycle
  } cntStrobe_t;

  // Conditions reported by the datapath to control
  typedef struct packed {
    logic curNz;     // stored interval is nonzero
    logic newNz;     // interval on the write bus is nonzero
    logic anyEn;     // at least one partition enabled
    logic badAcc;    // current access targets a disabled partition
    logic expiring;  // counter at its last cycle
  } cntStatus_t;

endpackage

// File: rtl/sdram_rfsh_datapath.sv
module sdram_rfsh_datapath
  import sdram_rfsh_pkg::*;
#(
  parameter int NUM_PART = 4,
  parameter int CNT_W    = 12,
  localparam int PART_W  = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  cntStrobe_t          strobe,
  input  logic [CNT_W-1:0]    cfgInterval,
  input  logic [NUM_PART-1:0] cfgPartEn,
  input  logic                accValid,
  input  logic [PART_W-1:0]   accPart,
  output cntStatus_t          status,
  output logic [CNT_W-1:0]    cntValue,
  output logic [CNT_W-1:0]    intervalVal,
  output logic [NUM_PART-1:0] partEnVal
);

  logic [CNT_W-1:0]    intervalReg;
  logic [NUM_PART-1:0] partEnReg;
  logic [CNT_W-1:0]    cntReg;
  logic [NUM_PART-1:0] missVec;

  // Per-partition decode of an access that hits a disabled partition
  for (genvar g = 0; g < NUM_PART; g++) begin : g_miss
    assign missVec[g] = accValid && (accPart == PART_W'(g)) && !partEnReg[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalReg <= '0;
      partEnReg   <= '0;
    end else if (strobe.cfgLoad) begin
      intervalReg <= cfgInterval;
      partEnReg   <= cfgPartEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (strobe.cfgLoad) begin
      cntReg <= cfgInterval;
    end else if (strobe.reload) begin
      cntReg <= intervalReg;
    end else if (strobe.dec) begin
      cntReg <= cntReg - CNT_W'(1);
    end
  end

  always_comb begin
    status.curNz    = (intervalReg != '0);
    status.newNz    = (cfgInterval != '0);
    status.anyEn    = |partEnReg;
    status.badAcc   = |missVec;
    status.expiring = (cntReg <= CNT_W'(1));
  end

  assign cntValue    = cntReg;
  assign intervalVal = intervalReg;
  assign partEnVal   = partEnReg;

endmodule

// File: rtl/sdram_rfsh_ctrl.sv
module sdram_rfsh_ctrl
  import sdram_rfsh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrite,
  input  logic       refreshAck,
  input  cntStatus_t status,
  output cntStrobe_t strobe,
  output logic       refreshReq
);

  logic counting;
  logic periodicHit;
  logic forcedHit;
  logic trigger;
  logic reqReg;

  assign counting    = status.curNz && status.anyEn;
  assign periodicHit = counting && status.expiring;
  assign forcedHit   = status.curNz && status.badAcc;

  // A write is judged on the interval it writes; otherwise the stored one
  assign trigger = cfgWrite ? status.newNz : (periodicHit || forcedHit);

  always_comb begin
    strobe.cfgLoad = cfgWrite;
    strobe.reload  = trigger && !cfgWrite;
    strobe.dec     = counting && !cfgWrite && !trigger;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqReg <= 1'b0;
    end else begin
      reqReg <= trigger || (reqReg && !refreshAck);
    end
  end

  assign refreshReq = reqReg;

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_rfsh_pkg::*;
#(
  parameter int NUM_PART = 4,
  parameter int CNT_W    = 12,
  localparam int PART_W  = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrite,
  input  logic [CNT_W-1:0]    cfgInterval,
  input  logic [NUM_PART-1:0] cfgPartEn,
  input  logic                accValid,
  input  logic [PART_W-1:0]   accPart,
  input  logic                clkChange,
  input  logic                refreshAck,
  output logic                refreshReq
);

  cntStrobe_t          strobe;
  cntStatus_t          status;
  logic [CNT_W-1:0]    cntValue;
  logic [CNT_W-1:0]    intervalVal;
  logic [NUM_PART-1:0] partEnVal;

  sdram_rfsh_datapath #(
    .NUM_PART (NUM_PART),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgInterval (cfgInterval),
    .cfgPartEn   (cfgPartEn),
    .accValid    (accValid),
    .accPart     (accPart),
    .status      (status),
    .cntValue    (cntValue),
    .intervalVal (intervalVal),
    .partEnVal   (partEnVal)
  );

  sdram_rfsh_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrite   (cfgWrite),
    .refreshAck (refreshAck),
    .status     (status),
    .strobe     (strobe),
    .refreshReq (refreshReq)
  );

endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
  parameter int NUM_PART = 4,
  parameter int CNT_W    = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWrite,
  input logic [CNT_W-1:0]    cfgInterval,
  input logic                accValid,
  input logic                clkChange,
  input logic                refreshAck,
  input logic                refreshReq,
  input logic [CNT_W-1:0]    cntValue,
  input logic [CNT_W-1:0]    intervalVal,
  input logic [NUM_PART-1:0] partEnVal
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && !refreshAck) |=> refreshReq); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && refreshAck && !cfgWrite && !accValid && cntValue > CNT_W'(1)) |=> !refreshReq); // R9

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (!refreshReq && intervalVal == '0 && !(cfgWrite && cfgInterval != '0)) |=> !refreshReq); // R3

  AST_WRITE_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgInterval != '0) |=> refreshReq); // R6

  AST_WRITE_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (cntValue == $past(cfgInterval))); // R6

  AST_ALLOFF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (partEnVal == '0 && !cfgWrite && !accValid) |=> $stable(cntValue)); // R7

  AST_CLKCHG_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (!refreshReq && clkChange && !cfgWrite && !accValid && cntValue > CNT_W'(1)) |=> !refreshReq); // R10

endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
  .NUM_PART (NUM_PART),
  .CNT_W    (CNT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWrite    (cfgWrite),
  .cfgInterval (cfgInterval),
  .accValid    (accValid),
  .clkChange   (clkChange),
  .refreshAck  (refreshAck),
  .refreshReq  (refreshReq),
  .cntValue    (cntValue),
  .intervalVal (intervalVal),
  .partEnVal   (partEnVal)
);

// File: tb/sim_sdram_refresh_sched.sv
`timescale 1ns/1ps
module sim_sdram_refresh_sched;

  localparam int NP = 4;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrite = 1'b0;
  logic [CW-1:0] cfgInterval = '0;
  logic [NP-1:0] cfgPartEn = '0;
  logic          accValid = 1'b0;
  logic [1:0]    accPart = '0;
  logic          clkChange = 1'b0;
  logic          refreshAck = 1'b0;
  logic          refreshReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_refresh_sched #(.NUM_PART(NP), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgInterval(cfgInterval),
    .cfgPartEn(cfgPartEn), .accValid(accValid), .accPart(accPart),
    .clkChange(clkChange), .refreshAck(refreshAck), .refreshReq(refreshReq)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input int iv, input logic [NP-1:0] pe);
    cfgInterval = CW'(iv);
    cfgPartEn   = pe;
    cfgWrite    = 1'b1;
    @(negedge clk);
    cfgWrite    = 1'b0;
  endtask

  task automatic doAck();
    refreshAck = 1'b1;
    @(negedge clk);
    refreshAck = 1'b0;
  endtask

  task automatic doAccess(input int p);
    accValid = 1'b1;
    accPart  = 2'(p);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic countToReq(input int lim, output int n);
    n = 0;
    while (!refreshReq && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic testReset();
    int n;
    chkEq("R1 reset req", int'(refreshReq), 0);
    countToReq(60, n);
    chkEq("R1 quiet after reset", n, 60);
    doAccess(2);
    chkEq("R1 access after reset", int'(refreshReq), 0);
  endtask

  task automatic testPeriodic(input int iv);
    int n;
    doWrite(iv, 4'hF);
    chkEq("R6 write raises req", int'(refreshReq), 1);
    doAck();
    chkEq("R8 ack drops req", int'(refreshReq), 0);
    countToReq(iv + 5, n);
    chkEq("R2 first period", n, iv - 1);
    doAck();
    countToReq(iv + 5, n);
    chkEq("R2 second period", n, iv - 1);
    doAck();
  endtask

  task automatic testBadAccess();
    int n;
    doWrite(10, 4'b0011);
    doAck();
    cyc(3);
    doAccess(2);
    chkEq("R4 disabled access req", int'(refreshReq), 1);
    doAck();
    countToReq(20, n);
    chkEq("R4 reload after access", n, 9);
    doAck();
  endtask

  task automatic testEnabledAccess();
    int n;
    doWrite(10, 4'b0011);
    doAck();
    doAccess(1);
    chkEq("R5 enabled access no req", int'(refreshReq), 0);
    countToReq(20, n);
    chkEq("R5 counter undisturbed", n, 8);
    doAck();
  endtask

  task automatic testClkChange();
    int n;
    doWrite(10, 4'hF);
    doAck();
    clkChange = 1'b1;
    @(negedge clk);
    clkChange = 1'b0;
    chkEq("R10 clkChange no req", int'(refreshReq), 0);
    countToReq(20, n);
    chkEq("R10 counter undisturbed", n, 8);
    doAck();
  endtask

  task automatic testRewriteSame();
    int n;
    doWrite(8, 4'hF);
    doAck();
    cyc(3);
    doWrite(8, 4'hF);
    chkEq("R6 same-value write req", int'(refreshReq), 1);
    doAck();
    countToReq(20, n);
    chkEq("R6 same-value reload", n, 7);
    doAck();
  endtask

  task automatic testAllOff();
    int n;
    doWrite(5, 4'h0);
    chkEq("R6 write with all off req", int'(refreshReq), 1);
    doAck();
    countToReq(20, n);
    chkEq("R7 counter frozen", n, 20);
    doAccess(3);
    chkEq("R7 access forces req", int'(refreshReq), 1);
    doAck();
    countToReq(20, n);
    chkEq("R7 still frozen", n, 20);
  endtask

  task automatic testZero();
    int n;
    doWrite(0, 4'hF);
    chkEq("R3 zero write no req", int'(refreshReq), 0);
    countToReq(30, n);
    chkEq("R3 zero quiet", n, 30);
    doWrite(0, 4'h0);
    doAccess(1);
    chkEq("R3 zero disabled access", int'(refreshReq), 0);
  endtask

  task automatic testMerge();
    int n;
    doWrite(6, 4'hF);
    cyc(15);
    chkEq("R8 held without ack", int'(refreshReq), 1);
    doWrite(6, 4'hF);
    doAck();
    chkEq("R9 one ack clears merged", int'(refreshReq), 0);
    countToReq(20, n);
    chkEq("R9 period after merge", n, 5);
    refreshAck  = 1'b1;
    cfgWrite    = 1'b1;
    cfgInterval = CW'(6);
    @(negedge clk);
    refreshAck  = 1'b0;
    cfgWrite    = 1'b0;
    chkEq("R9 trigger in ack cycle", int'(refreshReq), 1);
    doAck();
    chkEq("R8 final ack", int'(refreshReq), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    cyc(4);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPeriodic(2);
    testPeriodic(5);
    testPeriodic(17);
    testBadAccess();
    testEnabledAccess();
    testClkChange();
    testRewriteSame();
    testAllOff();
    testZero();
    testMerge();
    finishRun();
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

endmodule